// File: doc/BRIEF.md
# FET Override and Shutdown Controller

This block produces the four protection FET gate-enable outputs of a battery monitor: charge, precharge, discharge and predischarge. Each enable is the firmware request for that FET with every active disable source masked out. The disable sources are the host command bits, a charge-off pin and a discharge-off pin. A configuration bit switches the discharge-off pin into combined mode. In that mode it turns off all four FETs and the charge-off pin is left free for another use.

A reset/shutdown pin is low in normal operation. When it is high, the block drives a soft reset to the rest of the digital logic at once. During this soft reset the FET enables and the sticky fuse flag keep their values. If the pin stays high for a full second, counted in ticks of a slow time base, the block enters shutdown. Shutdown forces every FET off and raises power-off requests for the oscillators, the 1.8 V regulator, the preregulator and the two programmable regulators. Only the global power-on reset leaves shutdown.

Top module: `fet_guard_ctrl`

## Requirements
- R1: `soft_rst_o` follows `rst_shut_i` through a two-flop synchronizer. A level driven before clock edge k appears on `soft_rst_o` after edge k+1 and not after edge k.
- R2: While the synchronized reset/shutdown level is high and shutdown is not being entered, `fet_en_o` holds its value. Changes of `fw_fet_req_i`, `host_fet_dis_i` and the override pins have no effect on it.
- R3: After `TICK_HZ*HOLD_SEC` ticks counted while the synchronized reset/shutdown level is high, `shutdown_o` is set. On that same clock edge `fet_en_o` becomes 0 and all five `pwr_off_o` bits become 1. The bits are 0 oscillators, 1 1.8 V regulator, 2 preregulator, 3 programmable regulator A, 4 programmable regulator B.
- R4: A low synchronized reset/shutdown level clears the tick count. A later high period needs the full count again.
- R5: With `combined_mode_i`=0, an asserted `chg_off_i` clears `fet_en_o` bits 0 (CHG) and 1 (PCHG) and leaves bits 2 and 3 unchanged.
- R6: An asserted `dsg_off_i` clears `fet_en_o` bits 2 (DSG) and 3 (PDSG).
- R7: With `combined_mode_i`=1, an asserted `dsg_off_i` clears all four enables, and `chg_off_i` has no effect.
- R8: Outside soft reset and shutdown, each enable bit becomes fw_req AND NOT host_dis AND NOT pin_dis on the third edge after an override pin change and on the first edge after a firmware or host change. Releasing a pin does not re-enable a FET that the host still disables.
- R9: Shutdown is sticky until `rst_ni` is asserted. While in shutdown, `soft_rst_o` stays high, `fet_en_o` stays 0 and `pwr_off_o` stays all ones, whatever the pin and request inputs do.
- R10: While `rst_ni` is low, all outputs are 0.
- R11: `fuse_fire_i` sets `fuse_o` on the next edge. The flag stays set through soft reset and is cleared only by `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global power-on reset, active low, asynchronous |
| rst_shut_i | input | 1 | Reset/shutdown pin, asynchronous |
| chg_off_i | input | 1 | Charge-pair override pin, asynchronous |
| dsg_off_i | input | 1 | Discharge-pair (or combined) override pin, asynchronous |
| combined_mode_i | input | 1 | 1: discharge-off pin disables all four FETs |
| fw_fet_req_i | input | 4 | Firmware enable requests {PDSG,DSG,PCHG,CHG} |
| host_fet_dis_i | input | 4 | Host command disables, same bit order |
| tick_i | input | 1 | One-cycle pulse from the slow time base |
| fuse_fire_i | input | 1 | Fuse blow request |
| fet_en_o | output | 4 | FET gate enables {PDSG,DSG,PCHG,CHG} |
| soft_rst_o | output | 1 | Soft reset for general logic |
| shutdown_o | output | 1 | Shutdown state |
| pwr_off_o | output | 5 | Power-off requests per domain |
| fuse_o | output | 1 | Sticky fuse state |

## Verification
The last tick of the hold count can arrive in the same cycle as the reset/shutdown pin's falling edge. The bench drives the pin low and the final tick at the same falling clock edge. At that moment the synchronizer still shows the pin high, so the count completes and shutdown must be entered. Every FET must be off and every power-off request must be raised. The bench also releases a discharge override while a host disable is still present on DSG, and expects only PDSG to return.

// File: rtl/fet_guard_pkg.sv
package fet_guard_pkg;
  localparam int unsigned NUM_FETS = 4;
  localparam int unsigned NUM_PWR  = 5;

  typedef enum int unsigned {
    FET_CHG  = 0,
    FET_PCHG = 1,
    FET_DSG  = 2,
    FET_PDSG = 3
  } fet_idx_e;

  typedef enum int unsigned {
    PWR_OSC    = 0,
    PWR_LDO18  = 1,
    PWR_PREREG = 2,
    PWR_LDO_A  = 3,
    PWR_LDO_B  = 4
  } pwr_idx_e;
endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fg_hold_timer.sv
module fg_hold_timer #(
  parameter int unsigned HOLD_TICKS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic tick_i,
  output logic hit_o,
  output logic shutdown_o
);
  localparam int unsigned CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             shut_q;

  assign hit_o = level_i & tick_i & ~shut_q & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      shut_q <= 1'b0;
    end else begin
      if (!level_i || hit_o) cnt_q <= '0;
      else if (tick_i && !shut_q) cnt_q <= cnt_q + 1'b1;
      if (hit_o) shut_q <= 1'b1;
    end
  end

  assign shutdown_o = shut_q;

  assert_cnt_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_i |=> cnt_q == '0);

  assert_shut_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_q |=> shut_q);

  assert_shut_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shut_q) |-> $past(level_i) && $past(tick_i));
endmodule

// File: rtl/fg_fet_gate.sv
module fg_fet_gate #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] fw_req_i,
  input  logic [N-1:0] host_dis_i,
  input  logic [N-1:0] pin_dis_i,
  input  logic         freeze_i,
  input  logic         kill_i,
  output logic [N-1:0] fet_en_o
);
  logic [N-1:0] fet_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_fet
      logic allow;
      assign allow = fw_req_i[i] & ~host_dis_i[i] & ~pin_dis_i[i];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       fet_q[i] <= 1'b0;
        else if (kill_i)   fet_q[i] <= 1'b0;
        else if (!freeze_i) fet_q[i] <= allow;
      end

      assert_pin_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_dis_i[i] && !freeze_i) |=> !fet_q[i]);
    end
  endgenerate

  assign fet_en_o = fet_q;

  assert_freeze_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !kill_i) |=> $stable(fet_q));

  assert_kill_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> fet_q == '0);
endmodule

// File: rtl/fet_guard_ctrl.sv
module fet_guard_ctrl
  import fet_guard_pkg::*;
#(
  parameter int unsigned TICK_HZ  = 32,
  parameter int unsigned HOLD_SEC = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rst_shut_i,
  input  logic                chg_off_i,
  input  logic                dsg_off_i,
  input  logic                combined_mode_i,
  input  logic [NUM_FETS-1:0] fw_fet_req_i,
  input  logic [NUM_FETS-1:0] host_fet_dis_i,
  input  logic                tick_i,
  input  logic                fuse_fire_i,
  output logic [NUM_FETS-1:0] fet_en_o,
  output logic                soft_rst_o,
  output logic                shutdown_o,
  output logic [NUM_PWR-1:0]  pwr_off_o,
  output logic                fuse_o
);
  localparam int unsigned HOLD_TICKS = TICK_HZ * HOLD_SEC;

  logic [2:0] pins_s;
  logic       rst_shut_s, chg_off_s, dsg_off_s;
  logic       hit, shut_q;
  logic       chg_pair_dis, dsg_pair_dis;
  logic [NUM_FETS-1:0] pin_dis;
  logic       fuse_q;

  fg_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({dsg_off_i, chg_off_i, rst_shut_i}),
    .q_o    (pins_s)
  );
  assign rst_shut_s = pins_s[0];
  assign chg_off_s  = pins_s[1];
  assign dsg_off_s  = pins_s[2];

  fg_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (rst_shut_s),
    .tick_i     (tick_i),
    .hit_o      (hit),
    .shutdown_o (shut_q)
  );

  // combined mode: discharge-off pin covers both pairs, charge-off pin ignored
  assign chg_pair_dis = combined_mode_i ? dsg_off_s : chg_off_s;
  assign dsg_pair_dis = dsg_off_s;

  always_comb begin
    pin_dis           = '0;
    pin_dis[FET_CHG]  = chg_pair_dis;
    pin_dis[FET_PCHG] = chg_pair_dis;
    pin_dis[FET_DSG]  = dsg_pair_dis;
    pin_dis[FET_PDSG] = dsg_pair_dis;
  end

  fg_fet_gate #(.N(NUM_FETS)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fw_req_i   (fw_fet_req_i),
    .host_dis_i (host_fet_dis_i),
    .pin_dis_i  (pin_dis),
    .freeze_i   (rst_shut_s),
    .kill_i     (hit | shut_q),
    .fet_en_o   (fet_en_o)
  );

  // fuse state survives soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fuse_q <= 1'b0;
    else if (fuse_fire_i) fuse_q <= 1'b1;
  end

  assign fuse_o     = fuse_q;
  assign soft_rst_o = rst_shut_s | shut_q;
  assign shutdown_o = shut_q;
  assign pwr_off_o  = {NUM_PWR{shut_q}};

  assert_shut_all_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> (fet_en_o == '0) && (&pwr_off_o) && soft_rst_o);

  assert_chg_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_off_s && !combined_mode_i && !rst_shut_s) |=>
      !fet_en_o[FET_CHG] && !fet_en_o[FET_PCHG]);

  assert_dsg_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsg_off_s && !rst_shut_s) |=> !fet_en_o[FET_DSG] && !fet_en_o[FET_PDSG]);

  assert_combined_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (combined_mode_i && dsg_off_s && !rst_shut_s) |=> fet_en_o == '0);

  assert_fuse_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_o |=> fuse_o);
endmodule

// File: tb/fet_guard_ctrl_tb.sv
`timescale 1ns/1ps
module fet_guard_ctrl_tb;
  localparam int unsigned HOLD = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rst_shut, chg_off, dsg_off, combined, tick, fuse_fire;
  logic [3:0] fw_req, host_dis;
  logic [3:0] fet_en;
  logic       soft_rst, shutdown, fuse;
  logic [4:0] pwr_off;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fet_guard_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_shut_i(rst_shut), .chg_off_i(chg_off),
    .dsg_off_i(dsg_off), .combined_mode_i(combined), .fw_fet_req_i(fw_req),
    .host_fet_dis_i(host_dis), .tick_i(tick), .fuse_fire_i(fuse_fire),
    .fet_en_o(fet_en), .soft_rst_o(soft_rst), .shutdown_o(shutdown),
    .pwr_off_o(pwr_off), .fuse_o(fuse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rst_shut = 0; chg_off = 0; dsg_off = 0; combined = 0;
    tick = 0; fuse_fire = 0; fw_req = 4'h0; host_dis = 4'h0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fw_req = 4'hF; rst_shut = 1;
    cyc(3);
    check("R10 reset outputs", {fet_en, soft_rst, shutdown, pwr_off, fuse}, 32'h0);
    do_reset();
  endtask

  task automatic t_soft_latency();
    do_reset();
    rst_shut = 1'b1;
    cyc(1);
    check("R1 soft_rst after one edge", soft_rst, 1'b0);
    cyc(1);
    check("R1 soft_rst after two edges", soft_rst, 1'b1);
    rst_shut = 1'b0;
    cyc(2);
    check("R1 soft_rst release", soft_rst, 1'b0);
  endtask

  task automatic t_freeze();
    do_reset();
    fw_req = 4'hF;
    cyc(1);
    check("R8 fw request passes", fet_en, 4'hF);
    fuse_fire = 1'b1;
    cyc(1);
    fuse_fire = 1'b0;
    check("R11 fuse set", fuse, 1'b1);
    rst_shut = 1'b1;
    cyc(3);
    fw_req = 4'h0; host_dis = 4'hF; dsg_off = 1'b1;
    cyc(4);
    check("R2 fet held in soft reset", fet_en, 4'hF);
    check("R11 fuse kept in soft reset", fuse, 1'b1);
    rst_shut = 1'b0; dsg_off = 1'b0;
    cyc(3);
    check("R2 fet updates after release", fet_en, 4'h0);
  endtask

  task automatic t_chg_off();
    do_reset();
    fw_req = 4'hF;
    chg_off = 1'b1;
    cyc(2);
    check("R8 pin latency two edges", fet_en, 4'hF);
    cyc(1);
    check("R5 chg pair off", fet_en, 4'b1100);
    chg_off = 1'b0;
    cyc(3);
    check("R5 chg pair back", fet_en, 4'hF);
  endtask

  task automatic t_dsg_off();
    do_reset();
    fw_req = 4'hF;
    dsg_off = 1'b1;
    cyc(3);
    check("R6 dsg pair off", fet_en, 4'b0011);
    host_dis = 4'b0100;
    cyc(1);
    dsg_off = 1'b0;
    cyc(3);
    check("R8 host disable blocks DSG after release", fet_en, 4'b1011);
    host_dis = 4'h0;
    cyc(1);
    check("R8 host release restores", fet_en, 4'hF);
  endtask

  task automatic t_combined();
    do_reset();
    combined = 1'b1; fw_req = 4'hF;
    chg_off = 1'b1;
    cyc(4);
    check("R7 chg pin ignored in combined", fet_en, 4'hF);
    dsg_off = 1'b1;
    cyc(3);
    check("R7 combined all off", fet_en, 4'h0);
    dsg_off = 1'b0;
    cyc(3);
    check("R7 combined release", fet_en, 4'hF);
  endtask

  task automatic t_hold_abort();
    do_reset();
    fw_req = 4'hF;
    rst_shut = 1'b1;
    cyc(3);
    ticks(HOLD - 1);
    rst_shut = 1'b0;
    cyc(4);
    check("R4 no shutdown after short hold", shutdown, 1'b0);
    rst_shut = 1'b1;
    cyc(3);
    ticks(HOLD - 1);
    check("R4 count restarted", shutdown, 1'b0);
    rst_shut = 1'b0;
    cyc(4);
  endtask

  task automatic t_shutdown();
    do_reset();
    fw_req = 4'hF;
    cyc(1);
    rst_shut = 1'b1;
    cyc(3);
    ticks(HOLD - 1);
    check("R3 not yet shutdown", shutdown, 1'b0);
    check("R2 fet held before shutdown", fet_en, 4'hF);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R3 shutdown entered", shutdown, 1'b1);
    check("R3 fets off", fet_en, 4'h0);
    check("R3 power off all", pwr_off, 5'h1F);
    rst_shut = 1'b0;
    fw_req = 4'hF;
    cyc(5);
    check("R9 shutdown sticky", {shutdown, soft_rst, pwr_off, fet_en}, {1'b1, 1'b1, 5'h1F, 4'h0});
    rst_n = 1'b0;
    cyc(1);
    rst_n = 1'b1;
    cyc(1);
    check("R9 left on power-on reset", shutdown, 1'b0);
  endtask

  task automatic t_race();
    do_reset();
    fw_req = 4'hF;
    rst_shut = 1'b1;
    cyc(3);
    ticks(HOLD - 1);
    rst_shut = 1'b0;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R3 final tick with pin falling", shutdown, 1'b1);
    cyc(3);
    check("R9 stays after pin low", {shutdown, fet_en}, {1'b1, 4'h0});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_soft_latency();
    t_freeze();
    t_chg_off();
    t_dsg_off();
    t_combined();
    t_hold_abort();
    t_shutdown();
    t_race();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule